// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two page-table entries from physical memory. A request carries the virtual address and an access type. The walker first reads the entry in the top-level table of the current process, which the table-base input selects. If that entry is valid, it reads the entry in the second-level table that the first entry points to. It then reports either the physical address or a fault code. On success it also returns the final entry word, so that a translation buffer can be loaded from it.

The walker handles one request at a time. Its memory side is a single word-read channel. The read request stays asserted, with its address unchanged, until the response arrives, and that may take any number of cycles. Three fault kinds are kept apart so that software can react to each: a missing second-level table, a non-resident page, and an access the page does not allow.

Entry layout (both levels): bit 0 is valid, bit 1 allows read, bit 2 allows write, bit 3 allows execute, and bits 31:12 hold a page frame number. The frame number in a top-level entry is the page that holds the second-level table.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `res_valid` is 0 and `mem_rd_valid` is 0.
- R2: The first memory read of a walk goes to the table base plus 4 times virtual address bits 31:22.
- R3: If the top-level entry has bit 0 clear, the walk ends with `res_fault` = 2'b01 and issues no second memory read.
- R4: The second memory read goes to {top-level entry bits 31:12, 12'h000} plus 4 times virtual address bits 21:12.
- R5: If the second-level entry has bit 0 clear, the walk ends with `res_fault` = 2'b10.
- R6: A valid second-level entry whose rights do not cover the access ends with `res_fault` = 2'b11. The access codes are: 2'b00 read (needs bit 1), 2'b01 write (needs bit 2), 2'b10 execute (needs bit 3). Code 2'b11 is reserved and always faults.
- R7: A permitted walk ends with `res_fault` = 2'b00, `res_paddr` = {second-level entry bits 31:12, virtual address bits 11:0}, and `res_pte` equal to the second-level entry.
- R8: `mem_rd_valid` stays high and `mem_rd_addr` stays unchanged from the issue of a read until its response, for any response latency.
- R9: A request is accepted only when `req_ready` is high. `req_ready` stays low from acceptance until the cycle after the result. `res_valid` is high for exactly one cycle.
- R10: The table base is sampled when the request is accepted, so a change of `ptbr` during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 32 | Physical address of the current top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, so a request is accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access type (00 read, 01 write, 10 execute) |
| mem_rd_valid | output | 1 | Word read outstanding |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 2 | 00 ok, 01 no second-level table, 10 page absent, 11 rights |
| res_paddr | output | 32 | Translated physical address (valid when fault is 00) |
| res_pte | output | 32 | Final entry for loading a translation buffer |

## Verification
The walk is driven with successful reads, writes and executes on pages whose rights bits differ, so that each rights bit is tied to its own access code. The reserved code is also used on a page that allows everything. Invalid entries are placed at each level, one of them with a nonzero frame number, which shows that the fault depends only on the valid bit and that an early fault stops after one read. Extreme indices (0 and 1023 at both levels), memory latencies of 0, 3 and 7 wait cycles, and a base change in the middle of a walk separate the address arithmetic, the request holding and the capture of the base.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_NO_L2 = 2'b01,
      FLT_ABSENT = 2'b10,
      FLT_RIGHTS = 2'b11
   } fault_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_READ_L1,
      S_WAIT_L1,
      S_READ_L2,
      S_WAIT_L2,
      S_DONE,
      S_FAULT
   } walk_state_e;

   // entry flag positions (decoded by the walker and by the translation buffer)
   localparam int unsigned ENT_VALID = 0;
   localparam int unsigned ENT_RD    = 1;
   localparam int unsigned ENT_WR    = 2;
   localparam int unsigned ENT_EX    = 3;

endpackage

// File: rtl/ptw_entry_addr.sv
// Forms the byte address of one table entry: base + index * entry size.
module ptw_entry_addr #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned IDX_W   = 10,
   parameter int unsigned ENT_W   = 32
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned ENT_BYTES = ENT_W / 8;
   localparam int unsigned SHIFT     = $clog2(ENT_BYTES);

   if (ENT_W % 8 != 0 || (1 << SHIFT) != ENT_BYTES) begin : g_bad_ent
      $error("ptw_entry_addr: entry width must be a power-of-two byte count");
   end
   if (IDX_W + SHIFT > ADDR_W) begin : g_bad_idx
      $error("ptw_entry_addr: scaled index wider than address");
   end

   logic [ADDR_W-1:0] scaled;

   always_comb begin
      scaled = '0;
      scaled[IDX_W+SHIFT-1:0] = {idx, {SHIFT{1'b0}}};
   end

   assign addr = base + scaled;

endmodule

// File: rtl/ptw_rights.sv
// Decides whether an entry's rights permit the requested access.
module ptw_rights #(
   parameter bit EXEC_NEEDS_X = 1'b1
) (
   input  ptw_pkg::acc_e acc,
   input  logic          can_rd,
   input  logic          can_wr,
   input  logic          can_ex,
   output logic          allowed
);
   import ptw_pkg::*;

   if (EXEC_NEEDS_X) begin : g_split_exec
      always_comb begin
         unique case (acc)
            ACC_READ:  allowed = can_rd;
            ACC_WRITE: allowed = can_wr;
            ACC_EXEC:  allowed = can_ex;
            default:   allowed = 1'b0;
         endcase
      end
   end else begin : g_exec_as_read
      logic unused_ex;
      assign unused_ex = can_ex;
      always_comb begin
         unique case (acc)
            ACC_READ:  allowed = can_rd;
            ACC_WRITE: allowed = can_wr;
            ACC_EXEC:  allowed = can_rd;
            default:   allowed = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
   parameter int unsigned VA_W     = 32,
   parameter int unsigned PA_W     = 32,
   parameter int unsigned ENT_W    = 32,
   parameter int unsigned L1_IDX_W = 10,
   parameter int unsigned L2_IDX_W = 10,
   parameter int unsigned OFF_W    = 12,
   parameter bit          EXEC_NEEDS_X = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PA_W-1:0]  ptbr,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_acc,
   output logic             mem_rd_valid,
   output logic [PA_W-1:0]  mem_rd_addr,
   input  logic             mem_rsp_valid,
   input  logic [ENT_W-1:0] mem_rsp_data,
   output logic             res_valid,
   output logic [1:0]       res_fault,
   output logic [PA_W-1:0]  res_paddr,
   output logic [ENT_W-1:0] res_pte
);
   import ptw_pkg::*;

   localparam int unsigned PFN_W  = PA_W - OFF_W;
   localparam int unsigned L2_LSB = OFF_W;
   localparam int unsigned L1_LSB = OFF_W + L2_IDX_W;

   if (VA_W != L1_IDX_W + L2_IDX_W + OFF_W) begin : g_bad_va
      $error("ptw_walker: index and offset widths must cover the virtual address");
   end
   if (ENT_W < PFN_W + ENT_EX + 1) begin : g_bad_ent
      $error("ptw_walker: entry too narrow for frame number and flags");
   end

   walk_state_e       state, state_n;
   logic [VA_W-1:0]   vaddr_q;
   acc_e              acc_q;
   logic [PA_W-1:0]   base_q;
   logic [ENT_W-1:0]  ent_q;
   fault_e            fault_q;

   logic [PA_W-1:0]   l1_addr, l2_addr, l2_base;
   logic              rsp_ok_valid, rights_ok;

   assign l2_base = {ent_q[ENT_W-1 -: PFN_W], {OFF_W{1'b0}}};

   ptw_entry_addr #(.ADDR_W(PA_W), .IDX_W(L1_IDX_W), .ENT_W(ENT_W)) u_l1_addr (
      .base (base_q),
      .idx  (vaddr_q[L1_LSB +: L1_IDX_W]),
      .addr (l1_addr)
   );

   ptw_entry_addr #(.ADDR_W(PA_W), .IDX_W(L2_IDX_W), .ENT_W(ENT_W)) u_l2_addr (
      .base (l2_base),
      .idx  (vaddr_q[L2_LSB +: L2_IDX_W]),
      .addr (l2_addr)
   );

   ptw_rights #(.EXEC_NEEDS_X(EXEC_NEEDS_X)) u_rights (
      .acc     (acc_q),
      .can_rd  (mem_rsp_data[ENT_RD]),
      .can_wr  (mem_rsp_data[ENT_WR]),
      .can_ex  (mem_rsp_data[ENT_EX]),
      .allowed (rights_ok)
   );

   assign rsp_ok_valid = mem_rsp_data[ENT_VALID];

   // next-state sequencing
   always_comb begin
      state_n = state;
      unique case (state)
         S_IDLE:    if (req_valid) state_n = S_READ_L1;
         S_READ_L1: state_n = S_WAIT_L1;
         S_WAIT_L1: if (mem_rsp_valid) state_n = rsp_ok_valid ? S_READ_L2 : S_FAULT;
         S_READ_L2: state_n = S_WAIT_L2;
         S_WAIT_L2: if (mem_rsp_valid) state_n = (rsp_ok_valid && rights_ok) ? S_DONE : S_FAULT;
         S_DONE:    state_n = S_IDLE;
         S_FAULT:   state_n = S_IDLE;
         default:   state_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         vaddr_q <= '0;
         acc_q   <= ACC_READ;
         base_q  <= '0;
         ent_q   <= '0;
         fault_q <= FLT_NONE;
      end else begin
         state <= state_n;
         unique case (state)
            S_IDLE: begin
               fault_q <= FLT_NONE;
               if (req_valid) begin
                  vaddr_q <= req_vaddr;
                  acc_q   <= acc_e'(req_acc);
                  base_q  <= ptbr;
               end
            end
            S_WAIT_L1: begin
               if (mem_rsp_valid) begin
                  ent_q <= mem_rsp_data;
                  if (!rsp_ok_valid) fault_q <= FLT_NO_L2;
               end
            end
            S_WAIT_L2: begin
               if (mem_rsp_valid) begin
                  ent_q <= mem_rsp_data;
                  if (!rsp_ok_valid)   fault_q <= FLT_ABSENT;
                  else if (!rights_ok) fault_q <= FLT_RIGHTS;
                  else                 fault_q <= FLT_NONE;
               end
            end
            default: ;
         endcase
      end
   end

   assign req_ready    = (state == S_IDLE);
   assign mem_rd_valid = (state == S_READ_L1) || (state == S_WAIT_L1) ||
                         (state == S_READ_L2) || (state == S_WAIT_L2);
   assign mem_rd_addr  = (state == S_READ_L1 || state == S_WAIT_L1) ? l1_addr : l2_addr;
   assign res_valid    = (state == S_DONE) || (state == S_FAULT);
   assign res_fault    = fault_q;
   assign res_paddr    = {ent_q[ENT_W-1 -: PFN_W], vaddr_q[OFF_W-1:0]};
   assign res_pte      = ent_q;

   // R3: an invalid top-level entry faults at once, with no further read
   a_r3_no_second_read: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT_L1 && mem_rsp_valid && !mem_rsp_data[ENT_VALID])
      |=> (res_valid && res_fault == FLT_NO_L2 && !mem_rd_valid));

   // R5: an invalid second-level entry reports an absent page
   a_r5_absent_page: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT_L2 && mem_rsp_valid && !mem_rsp_data[ENT_VALID])
      |=> (res_valid && res_fault == FLT_ABSENT));

   // R7: a success result always carries a valid entry
   a_r7_ok_entry_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault == FLT_NONE) |-> res_pte[ENT_VALID]);

   // R8: an outstanding read is held unchanged until answered
   a_r8_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R9: acceptance closes the request port
   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9: result strobe lasts one cycle and never overlaps readiness
   a_r9_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   a_r9_result_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !req_ready);

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ptbr = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        res_valid;
   logic [1:0]  res_fault;
   logic [31:0] res_paddr;
   logic [31:0] res_pte;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptw_walker u_dut (
      .clk(clk), .rst_n(rst_n), .ptbr(ptbr),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_acc(req_acc),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .res_valid(res_valid), .res_fault(res_fault),
      .res_paddr(res_paddr), .res_pte(res_pte)
   );

   int checks = 0;
   int failures = 0;
   int done_cnt = 0;
   int hold_err = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // ---------------- memory model ----------------
   logic [31:0] mem [logic [31:0]];
   int          mem_lat = 0;
   logic        busy = 1'b0;
   int          cnt = 0;
   logic [31:0] addr_q = '0;
   logic [31:0] data_q = '0;
   logic        rsp_q = 1'b0;
   logic [31:0] rd_log [0:255];
   int          rd_cnt = 0;

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   assign mem_rsp_valid = rsp_q;
   assign mem_rsp_data  = data_q;

   always @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0; rsp_q <= 1'b0; cnt <= 0;
      end else if (rsp_q) begin
         rsp_q <= 1'b0; busy <= 1'b0;
      end else if (busy) begin
         if (cnt == 0) rsp_q <= 1'b1;
         else cnt <= cnt - 1;
      end else if (mem_rd_valid) begin
         busy   <= 1'b1;
         cnt    <= mem_lat;
         addr_q <= mem_rd_addr;
         data_q <= rd(mem_rd_addr);
         rd_log[rd_cnt[7:0]] <= mem_rd_addr;
         rd_cnt <= rd_cnt + 1;
      end
   end

   // R8 hold monitor
   always @(negedge clk) begin
      if (rst_n && busy && (!mem_rd_valid || mem_rd_addr != addr_q)) hold_err++;
   end

   // ---------------- scoreboard ----------------
   typedef struct packed {
      logic [1:0]  fault;
      logic [31:0] paddr;
      logic [31:0] pte;
      logic [1:0]  nreads;
      logic [31:0] a1;
      logic [31:0] a2;
   } exp_t;

   exp_t q[$];

   function automatic bit allows(input logic [1:0] acc, input logic [31:0] e);
      case (acc)
         2'b00: return e[1];
         2'b01: return e[2];
         2'b10: return e[3];
         default: return 1'b0;
      endcase
   endfunction

   function automatic exp_t predict(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] base);
      exp_t it;
      logic [31:0] e1, e2;
      it = '0;
      it.a1 = base + {20'h0, va[31:22], 2'b00};
      e1 = rd(it.a1);
      it.nreads = 2'd1;
      if (!e1[0]) begin
         it.fault = 2'b01;
      end else begin
         it.nreads = 2'd2;
         it.a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
         e2 = rd(it.a2);
         it.pte = e2;
         it.paddr = {e2[31:12], va[11:0]};
         if (!e2[0]) it.fault = 2'b10;
         else if (!allows(acc, e2)) it.fault = 2'b11;
         else it.fault = 2'b00;
      end
      return it;
   endfunction

   int  rd_base = 0;
   bit  prev_res = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (res_valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R9 unexpected result", 32'h1, 32'h0);
            end else begin
               exp_t it;
               string tag;
               it = q.pop_front();
               case (it.fault)
                  2'b01: tag = "R3";
                  2'b10: tag = "R5";
                  2'b11: tag = "R6";
                  default: tag = "R7";
               endcase
               check(res_fault == it.fault, {tag, " fault code"}, {30'h0, res_fault}, {30'h0, it.fault});
               check(rd_cnt - rd_base == int'(it.nreads), "R3 read count",
                     32'(rd_cnt - rd_base), {30'h0, it.nreads});
               check(rd_log[rd_base[7:0]] == it.a1, "R2/R10 top-level address", rd_log[rd_base[7:0]], it.a1);
               if (it.nreads == 2'd2)
                  check(rd_log[8'(rd_base + 1)] == it.a2, "R4 second-level address",
                        rd_log[8'(rd_base + 1)], it.a2);
               if (it.fault == 2'b00) begin
                  check(res_paddr == it.paddr, "R7 physical address", res_paddr, it.paddr);
                  check(res_pte == it.pte, "R7 returned entry", res_pte, it.pte);
               end
            end
            check(!req_ready, "R9 ready low with result", {31'h0, req_ready}, 32'h0);
            check(!prev_res, "R9 one-cycle result", {31'h0, prev_res}, 32'h0);
            rd_base = rd_cnt;
            done_cnt++;
         end
         prev_res = res_valid;
      end
   end

   // ---------------- driver ----------------
   task automatic issue(input logic [31:0] va, input logic [1:0] acc);
      q.push_back(predict(va, acc, ptbr));
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_vaddr = va;
      req_acc   = acc;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] va_of(input int l1, input int l2, input int off);
      return {l1[9:0], l2[9:0], off[11:0]};
   endfunction

   localparam logic [31:0] BASE_A = 32'h0001_0000;
   localparam logic [31:0] BASE_B = 32'h0005_0000;

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // page tables
      mem[32'h0001_000C] = {20'h00020, 12'h001};    // l1=3   -> table 0x20000
      mem[32'h0001_0028] = {20'h00030, 12'h000};    // l1=10  invalid, nonzero frame
      mem[32'h0001_0FFC] = {20'h00040, 12'h001};    // l1=1023 -> table 0x40000
      mem[32'h0002_0014] = {20'h12345, 12'h003};    // l2=5 read only
      mem[32'h0002_0018] = {20'h0BEEF, 12'h009};    // l2=6 exec only
      mem[32'h0002_001C] = {20'h00777, 12'h00F};    // l2=7 all rights
      mem[32'h0002_0000] = {20'h00555, 12'h005};    // l2=0 write only
      mem[32'h0004_0FFC] = {20'hFFFFF, 12'h007};    // l2=1023 read/write
      mem[32'h0005_0000] = {20'h00060, 12'h001};    // base B, l1=0
      mem[32'h0006_0000] = {20'h00ABC, 12'h003};    // base B, l2=0

      ptbr = BASE_A;
      repeat (3) @(negedge clk);
      // R1: during reset
      check(req_ready == 1'b1 && res_valid == 1'b0 && mem_rd_valid == 1'b0, "R1 reset outputs",
            {29'h0, req_ready, res_valid, mem_rd_valid}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && res_valid == 1'b0 && mem_rd_valid == 1'b0, "R1 after reset",
            {29'h0, req_ready, res_valid, mem_rd_valid}, 32'h4);

      mem_lat = 0;
      issue(va_of(3, 5, 12'hABC), 2'b00);   // R7 read ok
      issue(va_of(3, 5, 12'h123), 2'b01);   // R6 write denied
      issue(va_of(3, 6, 12'h010), 2'b10);   // R7 exec ok
      issue(va_of(3, 6, 12'h010), 2'b00);   // R6 read denied on exec page
      drain();

      mem_lat = 3;
      issue(va_of(3, 7, 12'h444), 2'b11);   // R6 reserved code always faults
      issue(va_of(3, 7, 12'h444), 2'b01);   // R7 write ok
      issue(va_of(3, 0, 12'h000), 2'b01);   // R4 index 0
      issue(va_of(9, 1, 12'h000), 2'b00);   // R3 missing entry
      issue(va_of(10, 1, 12'h000), 2'b00);  // R3 valid bit clear, frame nonzero
      drain();

      mem_lat = 7;
      issue(va_of(3, 8, 12'h000), 2'b00);   // R5 absent page
      issue(va_of(1023, 1023, 12'hFFF), 2'b01); // R2/R4 max indices
      drain();

      // R10: base changes after acceptance
      mem_lat = 2;
      ptbr = BASE_B;
      issue(va_of(0, 0, 12'h5A5), 2'b00);
      ptbr = BASE_A;
      drain();

      check(hold_err == 0, "R8 read held until response", hold_err, 0);
      check(done_cnt == 12, "R9 all requests completed", done_cnt, 12);
      finish_run();
   end

endmodule